// File: doc/BRIEF.md
# Parallel EPROM Programming Sequencer

This block drives the parallel programming port of a small microcontroller whose on-chip EPROM is written and checked from outside. A host requests one operation (signature read, code program, code verify, encryption-table program, one of three lock-bit programs, clock-mode program, clock-mode verify or lock-bit verify) together with an address and a data byte. The sequencer holds the target in its programming mode, drives a five-line mode selector with the pattern that belongs to the operation, and either fires a burst of timed low pulses on the programming strobe with the high-voltage enable held, or waits a settling time and captures the data bus for a verify.

Timing is counted in ticks of an internal timebase that restarts with every accepted request, so each interval is an exact number of clock cycles: one tick is `TICK_DIV` clocks, meant to be one microsecond. The captured byte is returned raw and also decoded into the clock-mode flag and the three lock-bit states.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset: `busy`=0, `done`=0, `strobe`=1, `vpp_en`=0, `tgt_rst`=0, `tgt_psen`=1, `tgt_sel`=0, `data_oe`=0.
- R2: A request with a known op code while idle is accepted at that clock edge; `busy` is 1 from the next cycle through the single cycle in which `done` is 1, and 0 after it.
- R3: While busy, `tgt_sel` (bit 4 down to bit 0 = select lines A..E, don't-care lines driven 0) carries, per op code: 0 signature 00000, 1 program code 10110, 2 verify code 00110, 3 program encryption 10100, 4 program lock 1 11110, 5 program lock 2 11000, 6 program lock 3 01010, 7 program clock mode 00100, 8 verify clock mode 00111, 9 verify lock bits 01000.
- R4: While busy, `tgt_rst` is 1 and `tgt_psen` is 0, except for op 4 where `tgt_psen` is 1.
- R5: For programming ops (1, 3, 4, 5, 6, 7), `vpp_en` rises at the first busy cycle, `strobe` stays high for one tick, then makes exactly `PULSES` low pulses of `LOW_TICKS` ticks each, each followed by `HIGH_TICKS` ticks high.
- R6: `vpp_en` is 1 for the whole burst and 0 in the `done` cycle and whenever idle.
- R7: For ops 0, 2, 8 and 9, `strobe` stays 1 and `vpp_en` 0 for the whole operation; the data bus is captured after `SETTLE_TICKS` ticks and `rd_data` shows it in the `done` cycle.
- R8: In the `done` cycle of op 8, `res_clk12` equals captured data bit 4 (1 = twelve-clock mode, 0 = six-clock mode).
- R9: In the `done` cycle of op 9, `res_sec[0]`, `res_sec[1]`, `res_sec[2]` equal captured data bits 7, 6 and 3 (lock bits 1, 2, 3).
- R10: A request while busy is ignored: the running operation keeps its length and pins, and no second operation follows.
- R11: Op codes 10 to 15 are ignored: `busy` stays 0.
- R12: `addr_out` holds the request address while busy; `data_oe` is 1 exactly while busy on a programming op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_op | input | 4 | Operation code |
| req_addr | input | ADDR_W | EPROM address for the operation |
| req_data | input | 8 | Byte to program |
| data_in | input | 8 | Data bus as returned by the target |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last cycle of an operation |
| tgt_rst | output | 1 | Target reset line |
| tgt_psen | output | 1 | Target program-store-enable line |
| tgt_sel | output | 5 | Mode select lines A..E |
| strobe | output | 1 | Programming strobe, active low |
| vpp_en | output | 1 | Enable for the external high-voltage switch |
| addr_out | output | ADDR_W | Address driven to the target |
| data_out | output | 8 | Byte driven to the target |
| data_oe | output | 1 | Output enable for `data_out` |
| rd_data | output | 8 | Byte captured by the last read or verify |
| res_clk12 | output | 1 | Decoded clock-mode flag |
| res_sec | output | 3 | Decoded lock bits 1..3 |

## Verification
The bench builds the block with `TICK_DIV`=2, `LOW_TICKS`=4, `HIGH_TICKS`=2, `PULSES`=5 and `SETTLE_TICKS`=2, so a full five-pulse burst lasts 63 cycles and every op code, including the pulse count, the lead and trailing intervals and the multi-tick settle, is compared cycle by cycle against a behavioural model. Short intervals also put a request landing in the middle of a burst, and unknown op codes while idle, within a few cycles of the edges they could disturb.

// File: rtl/eps_pkg.sv
// Shared types for the EPROM programming sequencer.
// Assumes op codes are 4 bits; codes at or above OP_COUNT are unknown.
package eps_pkg;

    typedef enum logic [3:0] {
        OP_SIG    = 4'd0,
        OP_PCODE  = 4'd1,
        OP_VCODE  = 4'd2,
        OP_PENC   = 4'd3,
        OP_PLK1   = 4'd4,
        OP_PLK2   = 4'd5,
        OP_PLK3   = 4'd6,
        OP_PCLK6  = 4'd7,
        OP_VCLK6  = 4'd8,
        OP_VLOCK  = 4'd9
    } op_e;

    localparam int OP_COUNT = 10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_SETTLE,
        ST_FIN
    } st_e;

    // True for op codes that run a strobe burst.
    function automatic logic op_writes(op_e op);
        case (op)
            OP_PCODE, OP_PENC, OP_PLK1, OP_PLK2, OP_PLK3, OP_PCLK6: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Select-line pattern, bit 4 = line A ... bit 0 = line E.
    function automatic logic [4:0] op_lines(op_e op);
        case (op)
            OP_SIG:   return 5'b00000;
            OP_PCODE: return 5'b10110;
            OP_VCODE: return 5'b00110;
            OP_PENC:  return 5'b10100;
            OP_PLK1:  return 5'b11110;
            OP_PLK2:  return 5'b11000;
            OP_PLK3:  return 5'b01010;
            OP_PCLK6: return 5'b00100;
            OP_VCLK6: return 5'b00111;
            OP_VLOCK: return 5'b01000;
            default:  return 5'b00000;
        endcase
    endfunction

endpackage

// File: rtl/eps_timebase.sv
// Tick generator: one-cycle tick every DIV clocks while run is high.
// Assumes the counter restarts from zero whenever run is low, so the
// first tick comes DIV cycles after run rises.
module eps_timebase #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Count clocks within one tick interval.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);

    generate
        if (DIV > 1) begin : g_spacing
            // R5: ticks never come on adjacent cycles
            a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/eps_pinmap.sv
// Target control decoder: reset, program-store-enable and select lines.
// Assumes the target stays in normal reset-low state while idle.
module eps_pinmap
    import eps_pkg::*;
(
    input  logic       busy,
    input  op_e        op,
    output logic       tgt_rst,
    output logic       tgt_psen,
    output logic [4:0] tgt_sel
);
    // Map the active operation to its pin levels.
    always_comb begin
        tgt_rst  = busy;
        tgt_psen = busy ? (op == OP_PLK1) : 1'b1;
        tgt_sel  = busy ? op_lines(op) : 5'b00000;
    end
endmodule

// File: rtl/eps_result.sv
// Verify decoder: splits the captured byte into clock-mode and lock flags.
// Assumes the byte was captured after the settle interval.
module eps_result (
    input  logic [7:0] rd_byte,
    output logic       clk12,
    output logic [2:0] lock
);
    // Pick the result bits out of the byte.
    always_comb begin
        clk12   = rd_byte[4];
        lock[0] = rd_byte[7];
        lock[1] = rd_byte[6];
        lock[2] = rd_byte[3];
    end
endmodule

// File: rtl/eps_seq.sv
// Operation sequencer: accepts a request, walks lead / pulse / settle
// intervals counted in ticks, and flags the capture and done cycles.
// Assumes tick comes from a timebase that runs only in timed states.
module eps_seq
    import eps_pkg::*;
#(
    parameter int PULSES       = 5,
    parameter int LOW_TICKS    = 100,
    parameter int HIGH_TICKS   = 10,
    parameter int SETTLE_TICKS = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [3:0] req_op,
    input  logic       tick,
    output logic       accept,
    output logic       busy,
    output logic       done,
    output logic       timing,
    output logic       strobe,
    output logic       vpp_en,
    output logic       capture,
    output logic       prog,
    output op_e        cur_op
);
    localparam int LEAD_TICKS = 1;
    localparam int TMAX = (LOW_TICKS > HIGH_TICKS)
                        ? ((LOW_TICKS > SETTLE_TICKS) ? LOW_TICKS : SETTLE_TICKS)
                        : ((HIGH_TICKS > SETTLE_TICKS) ? HIGH_TICKS : SETTLE_TICKS);
    localparam int TW = $clog2(TMAX + 1);
    localparam int PW = $clog2(PULSES + 1);

    st_e           st;
    logic [TW-1:0] tcnt;
    logic [TW-1:0] lim;
    logic [PW-1:0] pcnt;
    logic          seg_end;

    // Interval length of the current state, in ticks.
    always_comb begin
        case (st)
            ST_LOW:    lim = TW'(LOW_TICKS);
            ST_HIGH:   lim = TW'(HIGH_TICKS);
            ST_SETTLE: lim = TW'(SETTLE_TICKS);
            default:   lim = TW'(LEAD_TICKS);
        endcase
    end

    assign seg_end = tick && (tcnt == lim - 1'b1);
    assign accept  = (st == ST_IDLE) && req_valid && (req_op < 4'(OP_COUNT));

    // State, tick and pulse counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            tcnt   <= '0;
            pcnt   <= '0;
            cur_op <= OP_SIG;
        end else begin
            case (st)
                ST_IDLE: if (accept) begin
                    cur_op <= op_e'(req_op);
                    st     <= op_writes(op_e'(req_op)) ? ST_LEAD : ST_SETTLE;
                    tcnt   <= '0;
                    pcnt   <= '0;
                end
                ST_LEAD, ST_LOW, ST_SETTLE: if (seg_end) begin
                    tcnt <= '0;
                    st   <= (st == ST_LEAD) ? ST_LOW
                          : (st == ST_LOW)  ? ST_HIGH : ST_FIN;
                end else if (tick) begin
                    tcnt <= tcnt + 1'b1;
                end
                ST_HIGH: if (seg_end) begin
                    tcnt <= '0;
                    if (pcnt == PW'(PULSES - 1)) begin
                        st <= ST_FIN;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                        st   <= ST_LOW;
                    end
                end else if (tick) begin
                    tcnt <= tcnt + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Output levels decoded from the state.
    always_comb begin
        busy    = (st != ST_IDLE);
        done    = (st == ST_FIN);
        timing  = busy && !done;
        strobe  = (st != ST_LOW);
        vpp_en  = (st == ST_LEAD) || (st == ST_LOW) || (st == ST_HIGH);
        capture = (st == ST_SETTLE) && seg_end;
        prog    = busy && op_writes(cur_op);
    end

    // R5: a low strobe only ever happens with the high voltage on
    a_r5_low_has_vpp: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |-> vpp_en);
    // R7: read and verify ops never pulse or raise the voltage
    a_r7_verify_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !prog) |-> (strobe && !vpp_en));
    // R10: the running op cannot be replaced mid-sequence
    a_r10_op_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cur_op));
    // R2: done is the final busy cycle
    a_r2_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R6: voltage is off in the done cycle
    a_r6_vpp_off_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !vpp_en);
endmodule

// File: rtl/eprom_prog_seq.sv
// Top of the EPROM programming sequencer: timebase, sequencer, pin
// decoder, address/data latches and verify capture.
// Assumes data_in is stable by the end of the settle interval.
module eprom_prog_seq
    import eps_pkg::*;
#(
    parameter int ADDR_W       = 15,
    parameter int TICK_DIV     = 100,
    parameter int LOW_TICKS    = 100,
    parameter int HIGH_TICKS   = 10,
    parameter int PULSES       = 5,
    parameter int SETTLE_TICKS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic [7:0]        data_in,
    output logic              busy,
    output logic              done,
    output logic              tgt_rst,
    output logic              tgt_psen,
    output logic [4:0]        tgt_sel,
    output logic              strobe,
    output logic              vpp_en,
    output logic [ADDR_W-1:0] addr_out,
    output logic [7:0]        data_out,
    output logic              data_oe,
    output logic [7:0]        rd_data,
    output logic              res_clk12,
    output logic [2:0]        res_sec
);
    logic accept, timing, tick, capture, prog;
    op_e  cur_op;

    eps_timebase #(.DIV(TICK_DIV)) u_tb (
        .clk(clk), .rst_n(rst_n), .run(timing), .tick(tick)
    );

    eps_seq #(
        .PULSES(PULSES), .LOW_TICKS(LOW_TICKS),
        .HIGH_TICKS(HIGH_TICKS), .SETTLE_TICKS(SETTLE_TICKS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .tick(tick), .accept(accept), .busy(busy), .done(done),
        .timing(timing), .strobe(strobe), .vpp_en(vpp_en),
        .capture(capture), .prog(prog), .cur_op(cur_op)
    );

    eps_pinmap u_pins (
        .busy(busy), .op(cur_op),
        .tgt_rst(tgt_rst), .tgt_psen(tgt_psen), .tgt_sel(tgt_sel)
    );

    eps_result u_res (
        .rd_byte(rd_data), .clk12(res_clk12), .lock(res_sec)
    );

    // Latch address and data when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_out <= '0;
            data_out <= '0;
        end else if (accept) begin
            addr_out <= req_addr;
            data_out <= req_data;
        end
    end

    // Capture the data bus at the end of the settle interval.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data <= '0;
        else if (capture) rd_data <= data_in;
    end

    assign data_oe = prog;

    // R12: address held steady through an operation
    a_r12_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(addr_out));
    // R4: target kept in reset whenever the sequencer is working
    a_r4_target_reset: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_en |-> tgt_rst);
endmodule

// File: tb/eprom_prog_seq_tb.sv
module eprom_prog_seq_tb;
    localparam int AW = 15, DIV = 2, LOW = 4, HIGH = 2, NP = 5, SET = 2;

    logic          clk = 0, rst_n = 0, req_valid = 0;
    logic [3:0]    req_op = 0;
    logic [AW-1:0] req_addr = 0;
    logic [7:0]    req_data = 0, data_in = 0;
    logic          busy, done, tgt_rst, tgt_psen, strobe, vpp_en, data_oe, res_clk12;
    logic [4:0]    tgt_sel;
    logic [AW-1:0] addr_out;
    logic [7:0]    data_out, rd_data;
    logic [2:0]    res_sec;

    eprom_prog_seq #(.ADDR_W(AW), .TICK_DIV(DIV), .LOW_TICKS(LOW),
        .HIGH_TICKS(HIGH), .PULSES(NP), .SETTLE_TICKS(SET)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .data_in(data_in),
        .busy(busy), .done(done), .tgt_rst(tgt_rst), .tgt_psen(tgt_psen),
        .tgt_sel(tgt_sel), .strobe(strobe), .vpp_en(vpp_en),
        .addr_out(addr_out), .data_out(data_out), .data_oe(data_oe),
        .rd_data(rd_data), .res_clk12(res_clk12), .res_sec(res_sec));

    always #5 clk = ~clk;

    typedef struct packed {
        bit busy, done, stb, vpp, rst, psen, oe, res;
        bit [4:0]    sel;
        bit [7:0]    rd;
        bit [AW-1:0] addr;
        bit [3:0]    op;
    } exp_t;

    exp_t q[$];
    int   checks = 0, errs = 0;
    bit   cmp_on = 0, finished = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    function automatic exp_t idle_e();
        exp_t e = '0;
        e.stb = 1; e.psen = 1;
        return e;
    endfunction

    function automatic bit writes(int op);
        return op == 1 || op == 3 || op == 4 || op == 5 || op == 6 || op == 7;
    endfunction

    function automatic bit [4:0] sel_of(int op);
        case (op)
            1: return 5'b10110;  2: return 5'b00110;  3: return 5'b10100;
            4: return 5'b11110;  5: return 5'b11000;  6: return 5'b01010;
            7: return 5'b00100;  8: return 5'b00111;  9: return 5'b01000;
            default: return 5'b00000;
        endcase
    endfunction

    // Behavioural model: one expected record per clock of the operation.
    task automatic plan_op(int op, bit [AW-1:0] a, bit [7:0] din);
        exp_t e;
        q.push_back(idle_e());
        e = '0;
        e.busy = 1; e.rst = 1; e.psen = (op == 4); e.sel = sel_of(op);
        e.addr = a; e.oe = writes(op); e.op = 4'(op); e.stb = 1;
        if (writes(op)) begin
            e.vpp = 1;
            repeat (DIV) q.push_back(e);
            for (int p = 0; p < NP; p++) begin
                e.stb = 0; repeat (LOW * DIV) q.push_back(e);
                e.stb = 1; repeat (HIGH * DIV) q.push_back(e);
            end
            e.vpp = 0;
        end else begin
            repeat (SET * DIV) q.push_back(e);
            e.res = 1; e.rd = din;
        end
        e.done = 1;
        q.push_back(e);
    endtask

    // Compare every output with the model on each falling edge.
    always @(negedge clk) if (cmp_on) begin
        exp_t e;
        e = (q.size() > 0) ? q.pop_front() : idle_e();
        chk("R2 busy", busy, e.busy);
        chk("R2 done", done, e.done);
        chk(e.oe || !e.busy ? "R5 strobe" : "R7 strobe", strobe, e.stb);
        chk("R6 vpp_en", vpp_en, e.vpp);
        chk("R4 tgt_rst", tgt_rst, e.rst);
        chk("R4 tgt_psen", tgt_psen, e.psen);
        chk("R3 tgt_sel", tgt_sel, e.sel);
        chk("R12 data_oe", data_oe, e.oe);
        if (e.busy) chk("R12 addr_out", addr_out, e.addr);
        if (e.res) begin
            chk("R7 rd_data", rd_data, e.rd);
            if (e.op == 8) chk("R8 res_clk12", res_clk12, e.rd[4]);
            if (e.op == 9) chk("R9 res_sec", res_sec, {e.rd[3], e.rd[6], e.rd[7]});
        end
    end

    // Issue one request; poke_at > 0 adds an ignored request that many cycles in.
    task automatic run_op(int op, bit [AW-1:0] a, bit [7:0] d, bit [7:0] din, int poke_at);
        @(posedge clk); #2;
        data_in = din; req_op = 4'(op); req_addr = a; req_data = d; req_valid = 1;
        plan_op(op, a, din);
        @(posedge clk); #2;
        req_valid = 0;
        if (poke_at > 0) begin
            repeat (poke_at) @(posedge clk);
            #2; req_op = 4'd9; req_addr = ~a; req_valid = 1;   // R10 ignored request
            @(posedge clk); #2; req_valid = 0;
        end
        while (q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        @(negedge clk);
        chk("R1 busy", busy, 0);  chk("R1 strobe", strobe, 1);
        chk("R1 vpp_en", vpp_en, 0); chk("R1 tgt_rst", tgt_rst, 0);
        chk("R1 tgt_psen", tgt_psen, 1); chk("R1 tgt_sel", tgt_sel, 0);
        chk("R1 data_oe", data_oe, 0); chk("R1 done", done, 0);
        @(posedge clk); #2;
        rst_n = 1;
        cmp_on = 1;
        run_op(0, 15'h0030, 8'h00, 8'h15, 0);
        run_op(1, 15'h1234, 8'hA5, 8'h00, 0);
        run_op(2, 15'h1234, 8'h00, 8'hA5, 0);
        run_op(3, 15'h0007, 8'h3C, 8'h00, 0);
        run_op(4, 15'h0000, 8'h00, 8'h00, 0);
        run_op(5, 15'h0001, 8'h00, 8'h00, 0);
        run_op(6, 15'h0002, 8'h00, 8'h00, 0);
        run_op(7, 15'h0000, 8'h00, 8'h00, 0);
        run_op(8, 15'h0000, 8'h00, 8'h10, 0);   // R8 twelve-clock
        run_op(8, 15'h0000, 8'h00, 8'hEF, 0);   // R8 six-clock
        run_op(9, 15'h0000, 8'h00, 8'hC8, 0);   // R9 all locks set
        run_op(9, 15'h0000, 8'h00, 8'h40, 0);   // R9 lock 2 only
        run_op(9, 15'h0000, 8'h00, 8'h37, 0);   // R9 none set
        run_op(1, 15'h7FFF, 8'h5A, 8'h00, 9);   // R10 request inside a burst
        run_op(0, 15'h0001, 8'h00, 8'hFF, 1);   // R10 request inside a settle
        // R11: unknown op codes while idle
        for (int c = 10; c < 16; c++) begin
            @(posedge clk); #2; req_op = 4'(c); req_valid = 1;
            @(posedge clk); #2; req_valid = 0;
            @(negedge clk);
            chk("R11 busy after unknown op", busy, 0);
        end
        repeat (3) @(posedge clk);
        summary();
    end
endmodule